// File: doc/BRIEF.md
# USB Transmit Packet Serializer

This block holds one outgoing packet image for a USB endpoint and puts it on the data pair when the host polls the endpoint. Firmware opens an image and writes it one byte per cycle: a sync byte, a PID, the payload, and a terminating FFh byte. The CRC16 can be supplied by firmware as part of the image. If firmware instead puts a nonzero payload length in the 4-bit select value given when the image is opened, the block computes the CRC16 itself and appends it.

When a token decoder upstream reports a matching IN token, the block transmits the stored image. If no image is stored, it answers with a NAK handshake. An endpoint-0 build also accepts SETUP tokens: with nothing stored it answers them with ACK. Every byte goes out least significant bit first, with a stuffed zero after each run of six ones and NRZI coding on the line, and the packet finishes with an end-of-packet pattern. Once a data packet has been sent the image is discarded.

Top module: `usb_tx_serializer`

## Requirements
- R1: Whenever no packet is on the line, including right after reset, `usb_oe` is low and both `usb_dp` and `usb_dm` are 0.
- R2: Opening with select value 0 selects firmware CRC. Written bytes are stored in order. The first FFh written at image position 2 or later closes the image and is not stored. The transmitted packet is exactly the stored bytes.
- R3: Opening with select value N (1..DATA_MAX; larger values count as DATA_MAX) stores sync, PID and N payload bytes. The next write closes the image and its value is discarded. The packet is sync, PID, the N payload bytes, and then the CRC16 of the payload alone (polynomial x^16+x^15+x^2+1, register seeded with all ones, remainder complemented), low byte first.
- R4: A packet starts from the J state (dp=1, dm=0) and lasts one bit time of CLKS_PER_BIT clocks per bit. Bytes are sent LSB first. A 0 bit toggles the line and a 1 bit holds it.
- R5: After six consecutive 1 bits a 0 bit is inserted. The run count carries across byte boundaries and through the CRC bytes.
- R6: The last bit is followed by two bit times of SE0 (dp=dm=0), then one bit time of J, and then `usb_oe` falls.
- R7: An IN token while no image is closed is answered with the two bytes 80h, 5Ah (sync, NAK).
- R8: With IS_EP0=1, a SETUP token is answered with 80h, D2h (sync, ACK) when no image is closed, and with the image when one is. With IS_EP0=0, a SETUP token produces no output.
- R9: After a data packet has been transmitted, the image is empty, so the next IN token is answered with NAK.
- R10: A token that arrives while a packet is being sent is ignored, so exactly one packet appears on the line.
- R11: Writes to a closed image are ignored until it has been sent. The packet then carries the bytes written before closing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| img_open | input | 1 | Pulse: discard the image and start a new one |
| img_sel | input | 4 | Payload count for hardware CRC; 0 selects firmware CRC |
| img_wr | input | 1 | Write strobe for one image byte |
| img_byte | input | 8 | Image byte |
| tok_in | input | 1 | Pulse: matching IN token seen |
| tok_setup | input | 1 | Pulse: matching SETUP token seen |
| usb_dp | output | 1 | Positive data line level |
| usb_dm | output | 1 | Negative data line level |
| usb_oe | output | 1 | Line driver enable |

## Verification
The bench builds two instances, both with CLKS_PER_BIT=4 and DATA_MAX=8. One is an endpoint-0 build (IS_EP0=1) and the other is not (IS_EP0=0), so both SETUP answers can be observed side by side. The four-clock bit time keeps an 8-byte all-ones payload, with its stuffed bits and CRC, short enough to decode bit by bit from the pins. DATA_MAX=8 places the maximum payload and the clamping of an oversized select value within a single test. The decoder on the bench undoes the NRZI coding and the bit stuffing independently of the design, and computes the expected CRC with the shift-left polynomial form of the CRC.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam logic [7:0] PID_NAK   = 8'h5A;
    localparam logic [7:0] PID_ACK   = 8'hD2;
    localparam logic [7:0] STOP_BYTE = 8'hFF;

    // reflected form of x^16+x^15+x^2+1
    localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

    typedef enum logic [2:0] {
        EN_IDLE,
        EN_SEND,
        EN_EOP1,
        EN_EOP2,
        EN_EOPJ
    } enc_phase_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_WAIT
    } seq_phase_t;

    typedef enum logic [1:0] {
        PK_DATA,
        PK_NAK,
        PK_ACK
    } pkt_kind_t;

endpackage

// File: rtl/tx_image_store.sv
module tx_image_store
    import usb_tx_pkg::*;
#(
    parameter int DATA_MAX = 8,
    localparam int DEPTH = DATA_MAX + 4,
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open_i,
    input  logic [3:0]    sel_i,
    input  logic          wr_i,
    input  logic [7:0]    byte_i,
    input  logic          lock_i,
    input  logic          consume_i,
    input  logic [PW-1:0] rd_idx_i,
    output logic [7:0]    rd_byte_o,
    output logic          ready_o,
    output logic          hw_crc_o,
    output logic [PW-1:0] n_data_o,
    output logic [PW-1:0] len_o
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PW-1:0]         wptr;
        logic [PW-1:0]         n;
        logic                  hw;
        logic                  ready;
    } store_t;

    store_t q, d;
    logic   close_now;

    always_comb begin
        d         = q;
        close_now = 1'b0;
        if (consume_i) begin
            d.ready = 1'b0;
            d.wptr  = '0;
        end else if (open_i && !lock_i) begin
            d.ready = 1'b0;
            d.wptr  = '0;
            d.hw    = (sel_i != 4'd0);
            d.n     = (int'(sel_i) > DATA_MAX) ? PW'(DATA_MAX) : PW'(sel_i);
        end else if (wr_i && !q.ready) begin
            if (q.hw) begin
                close_now = (q.wptr == PW'(2) + q.n);
            end else begin
                close_now = (byte_i == STOP_BYTE) && (q.wptr >= PW'(2));
            end
            if (close_now) begin
                d.ready = 1'b1;
            end else if (q.wptr < PW'(DEPTH)) begin
                d.mem[q.wptr] = byte_i;
                d.wptr        = q.wptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_byte_o = (rd_idx_i < PW'(DEPTH)) ? q.mem[rd_idx_i] : 8'h00;
    assign ready_o   = q.ready;
    assign hw_crc_o  = q.hw;
    assign n_data_o  = q.n;
    assign len_o     = q.wptr;

    // R11: a closed image is frozen until consumed or reopened
    a_r11_closed_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ready && !consume_i && !open_i) |=> ($stable(q.mem) && $stable(q.wptr)));

    // R2: the write pointer never runs past the storage
    a_r2_wptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.wptr <= PW'(DEPTH));

endmodule

// File: rtl/tx_crc16.sv
module tx_crc16
    import usb_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seed_i,
    input  logic       en_i,
    input  logic [7:0] din_i,
    output logic [7:0] crc_lo_o,
    output logic [7:0] crc_hi_o
);

    logic [15:0] crc_q, crc_d, step;

    always_comb begin
        step = crc_q;
        for (int i = 0; i < 8; i++) begin
            if (step[0] ^ din_i[i]) begin
                step = (step >> 1) ^ CRC_POLY_REFL;
            end else begin
                step = step >> 1;
            end
        end
        if (seed_i) begin
            crc_d = 16'hFFFF;
        end else if (en_i) begin
            crc_d = step;
        end else begin
            crc_d = crc_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= 16'hFFFF;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc_lo_o = ~crc_q[7:0];
    assign crc_hi_o = ~crc_q[15:8];

endmodule

// File: rtl/tx_line_encoder.sv
module tx_line_encoder
    import usb_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8,
    localparam int DW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  logic [7:0] push_byte_i,
    input  logic       push_last_i,
    output logic       full_o,
    output logic       done_o,
    output logic       dp_o,
    output logic       dm_o,
    output logic       oe_o
);

    typedef struct packed {
        logic [DW-1:0] div;
        enc_phase_t    phase;
        logic [7:0]    sh;
        logic [3:0]    cnt;
        logic          slast;
        logic [7:0]    hold;
        logic          hv;
        logic          hlast;
        logic [2:0]    ones;
        logic          line;
        logic          se0;
        logic          oe;
    } enc_t;

    enc_t q, d;
    logic tick, emit, ebit, base_line;
    logic [2:0] base_ones;

    assign tick = (q.div == DW'(CLKS_PER_BIT - 1));

    always_comb begin
        d         = q;
        emit      = 1'b0;
        ebit      = 1'b0;
        base_line = q.line;
        base_ones = q.ones;
        d.div     = tick ? '0 : q.div + 1'b1;
        if (push_i && !q.hv) begin
            d.hold  = push_byte_i;
            d.hv    = 1'b1;
            d.hlast = push_last_i;
        end
        if (tick) begin
            case (q.phase)
                EN_IDLE: begin
                    if (q.hv) begin
                        d.phase   = EN_SEND;
                        d.oe      = 1'b1;
                        d.se0     = 1'b0;
                        base_line = 1'b1;
                        base_ones = 3'd0;
                        emit      = 1'b1;
                        ebit      = q.hold[0];
                        d.sh      = {1'b0, q.hold[7:1]};
                        d.cnt     = 4'd7;
                        d.slast   = q.hlast;
                        d.hv      = 1'b0;
                    end
                end
                EN_SEND: begin
                    if (q.ones == 3'd6) begin
                        emit = 1'b1;
                    end else if (q.cnt != 4'd0) begin
                        emit  = 1'b1;
                        ebit  = q.sh[0];
                        d.sh  = {1'b0, q.sh[7:1]};
                        d.cnt = q.cnt - 1'b1;
                    end else if (q.hv) begin
                        emit    = 1'b1;
                        ebit    = q.hold[0];
                        d.sh    = {1'b0, q.hold[7:1]};
                        d.cnt   = 4'd7;
                        d.slast = q.hlast;
                        d.hv    = 1'b0;
                    end else begin
                        d.phase = EN_EOP1;
                        d.se0   = 1'b1;
                    end
                end
                EN_EOP1: d.phase = EN_EOP2;
                EN_EOP2: begin
                    d.se0   = 1'b0;
                    d.line  = 1'b1;
                    d.phase = EN_EOPJ;
                end
                EN_EOPJ: begin
                    d.oe    = 1'b0;
                    d.phase = EN_IDLE;
                end
                default: d.phase = EN_IDLE;
            endcase
        end
        if (emit) begin
            d.line = ebit ? base_line : ~base_line;
            d.ones = ebit ? base_ones + 3'd1 : 3'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= EN_IDLE;
            q.line  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign full_o = q.hv;
    assign done_o = tick && (q.phase == EN_EOPJ);
    assign oe_o   = q.oe;
    assign dp_o   = q.oe && !q.se0 && q.line;
    assign dm_o   = q.oe && !q.se0 && !q.line;

    // R5: six ones in a row are always followed by a line toggle
    a_r5_stuff_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == EN_SEND && tick && q.ones == 3'd6) |=> (q.line != $past(q.line)));

    // R4: the byte feed never runs dry in the middle of a packet
    a_r4_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == EN_SEND && tick && q.ones != 3'd6 && q.cnt == 4'd0 && !q.hv) |-> q.slast);

    // R6: SE0 lasts beyond its first clock
    a_r6_se0_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.se0) |=> q.se0);

    // R6: SE0 ends into a driven J
    a_r6_j_after_se0: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.se0) |-> (q.oe && q.line));

endmodule

// File: rtl/usb_tx_serializer.sv
module usb_tx_serializer
    import usb_tx_pkg::*;
#(
    parameter int DATA_MAX     = 8,
    parameter int CLKS_PER_BIT = 8,
    parameter int IS_EP0       = 1,
    localparam int DEPTH = DATA_MAX + 4,
    localparam int PW    = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       img_open,
    input  logic [3:0] img_sel,
    input  logic       img_wr,
    input  logic [7:0] img_byte,
    input  logic       tok_in,
    input  logic       tok_setup,
    output logic       usb_dp,
    output logic       usb_dm,
    output logic       usb_oe
);

    localparam logic SETUP_EN = (IS_EP0 != 0);

    typedef struct packed {
        seq_phase_t    phase;
        pkt_kind_t     kind;
        logic [PW-1:0] idx;
    } seq_t;

    seq_t q, d;

    logic          img_ready, img_hw, consume, lock;
    logic [PW-1:0] img_n, img_len;
    logic [7:0]    mem_byte, crc_lo, crc_hi;
    logic          enc_full, enc_done;
    logic          push, crc_en, crc_seed, setup_ok;
    logic [7:0]    sel_byte;
    logic          sel_last;

    assign setup_ok = tok_setup && SETUP_EN;
    assign lock     = (q.phase != SQ_IDLE) && (q.kind == PK_DATA);
    assign crc_seed = (q.phase == SQ_IDLE);

    tx_image_store #(.DATA_MAX(DATA_MAX)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_i    (img_open),
        .sel_i     (img_sel),
        .wr_i      (img_wr),
        .byte_i    (img_byte),
        .lock_i    (lock),
        .consume_i (consume),
        .rd_idx_i  (q.idx),
        .rd_byte_o (mem_byte),
        .ready_o   (img_ready),
        .hw_crc_o  (img_hw),
        .n_data_o  (img_n),
        .len_o     (img_len)
    );

    tx_crc16 u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .seed_i   (crc_seed),
        .en_i     (crc_en),
        .din_i    (mem_byte),
        .crc_lo_o (crc_lo),
        .crc_hi_o (crc_hi)
    );

    tx_line_encoder #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_byte_i (sel_byte),
        .push_last_i (sel_last),
        .full_o      (enc_full),
        .done_o      (enc_done),
        .dp_o        (usb_dp),
        .dm_o        (usb_dm),
        .oe_o        (usb_oe)
    );

    // byte selection for the current packet position
    always_comb begin
        sel_byte = SYNC_BYTE;
        sel_last = 1'b0;
        case (q.kind)
            PK_NAK: begin
                sel_byte = (q.idx == '0) ? SYNC_BYTE : PID_NAK;
                sel_last = (q.idx == PW'(1));
            end
            PK_ACK: begin
                sel_byte = (q.idx == '0) ? SYNC_BYTE : PID_ACK;
                sel_last = (q.idx == PW'(1));
            end
            default: begin
                if (img_hw) begin
                    if (q.idx < PW'(2) + img_n) begin
                        sel_byte = mem_byte;
                    end else if (q.idx == PW'(2) + img_n) begin
                        sel_byte = crc_lo;
                    end else begin
                        sel_byte = crc_hi;
                    end
                    sel_last = (q.idx == PW'(3) + img_n);
                end else begin
                    sel_byte = mem_byte;
                    sel_last = (q.idx == img_len - PW'(1));
                end
            end
        endcase
    end

    always_comb begin
        d       = q;
        push    = 1'b0;
        consume = 1'b0;
        crc_en  = 1'b0;
        case (q.phase)
            SQ_IDLE: begin
                if (tok_in) begin
                    d.phase = SQ_RUN;
                    d.idx   = '0;
                    d.kind  = img_ready ? PK_DATA : PK_NAK;
                end else if (setup_ok) begin
                    d.phase = SQ_RUN;
                    d.idx   = '0;
                    d.kind  = img_ready ? PK_DATA : PK_ACK;
                end
            end
            SQ_RUN: begin
                if (!enc_full) begin
                    push   = 1'b1;
                    crc_en = (q.kind == PK_DATA) && img_hw &&
                             (q.idx >= PW'(2)) && (q.idx < PW'(2) + img_n);
                    d.idx  = q.idx + 1'b1;
                    if (sel_last) begin
                        d.phase = SQ_WAIT;
                    end
                end
            end
            SQ_WAIT: begin
                if (enc_done) begin
                    d.phase = SQ_IDLE;
                    consume = (q.kind == PK_DATA);
                end
            end
            default: d.phase = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.phase <= SQ_IDLE;
            q.kind  <= PK_NAK;
            q.idx   <= '0;
        end else begin
            q <= d;
        end
    end

    // R1: nothing is driven while the sequencer is idle
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == SQ_IDLE) |-> !usb_oe);

    // R9: a sent data packet empties the image
    a_r9_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == SQ_WAIT && enc_done && q.kind == PK_DATA) |=> !img_ready);

    // R10: the packet kind does not change while a packet is in flight
    a_r10_kind_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase != SQ_IDLE) |=> $stable(q.kind));

endmodule

// File: tb/usb_tx_serializer_test.sv
module usb_tx_serializer_test;

    localparam int CPB  = 4;
    localparam int DMAX = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       img_open = 1'b0, img_wr = 1'b0;
    logic [3:0] img_sel = 4'd0;
    logic [7:0] img_byte = 8'h00;
    logic       tok_in_a = 1'b0, tok_setup_a = 1'b0;
    logic       tok_in_b = 1'b0, tok_setup_b = 1'b0;
    logic       dp_a, dm_a, oe_a, dp_b, dm_b, oe_b;

    usb_tx_serializer #(.DATA_MAX(DMAX), .CLKS_PER_BIT(CPB), .IS_EP0(1)) uut (
        .clk(clk), .rst_n(rst_n), .img_open(img_open), .img_sel(img_sel),
        .img_wr(img_wr), .img_byte(img_byte), .tok_in(tok_in_a),
        .tok_setup(tok_setup_a), .usb_dp(dp_a), .usb_dm(dm_a), .usb_oe(oe_a));

    usb_tx_serializer #(.DATA_MAX(DMAX), .CLKS_PER_BIT(CPB), .IS_EP0(0)) uut_b (
        .clk(clk), .rst_n(rst_n), .img_open(1'b0), .img_sel(4'd0),
        .img_wr(1'b0), .img_byte(8'h00), .tok_in(tok_in_b),
        .tok_setup(tok_setup_b), .usb_dp(dp_b), .usb_dm(dm_b), .usb_oe(oe_b));

    int total = 0;
    int bad   = 0;

    logic [7:0] rx [0:31];
    int         rx_n;
    bit         rx_stuff_ok, rx_eop_ok, rx_align_ok;
    logic [7:0] ex [0:31];
    int         ex_n;
    logic [7:0] wbuf [0:15];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] line_of(input bit b);
        return b ? {oe_b, dp_b, dm_b} : {oe_a, dp_a, dm_a};
    endfunction

    // expected CRC, shift-left form; returns {second byte, first byte}
    function automatic logic [15:0] crc_bytes(input int first, input int n);
        logic [15:0] c = 16'hFFFF;
        logic [15:0] r;
        logic [7:0]  lo, hi;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                logic fb;
                fb = c[15] ^ ex[first + i][k];
                c  = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h8005;
            end
        end
        r = ~c;
        for (int i = 0; i < 8; i++) begin
            lo[i] = r[15 - i];
            hi[i] = r[7 - i];
        end
        return {hi, lo};
    endfunction

    task automatic capture(input bit b, output bit got);
        int waitc = 0;
        int ones = 0, nb = 0, guard = 0;
        bit prev = 1'b1, se0 = 1'b0, bitv;
        logic [7:0] cur = 8'h00;
        logic [2:0] s;
        got = 1'b0;
        rx_n = 0; rx_stuff_ok = 1'b1; rx_eop_ok = 1'b0; rx_align_ok = 1'b0;
        while (!line_of(b)[2] && waitc < 400) begin
            @(negedge clk);
            waitc++;
        end
        if (!line_of(b)[2]) return;
        got = 1'b1;
        while (!se0 && guard < 3000) begin
            s = line_of(b);
            guard++;
            if (!s[1] && !s[0]) begin
                se0 = 1'b1;
            end else begin
                bitv = (s[1] == prev);
                prev = s[1];
                if (ones == 6) begin
                    if (bitv) rx_stuff_ok = 1'b0;
                    ones = 0;
                end else begin
                    cur[nb] = bitv;
                    nb++;
                    ones = bitv ? ones + 1 : 0;
                    if (nb == 8) begin
                        if (rx_n < 32) rx[rx_n] = cur;
                        rx_n++;
                        nb = 0;
                    end
                end
                repeat (CPB) @(negedge clk);
            end
        end
        rx_align_ok = (nb == 0);
        rx_eop_ok = se0 && line_of(b)[2];
        repeat (CPB) @(negedge clk);
        s = line_of(b);
        if (!(s == 3'b100)) rx_eop_ok = 1'b0;
        repeat (CPB) @(negedge clk);
        s = line_of(b);
        if (!(s == 3'b110)) rx_eop_ok = 1'b0;
        repeat (CPB) @(negedge clk);
        s = line_of(b);
        if (!(s == 3'b000)) rx_eop_ok = 1'b0;
    endtask

    task automatic check_pkt(input string req, input bit got);
        int mism = -1;
        chk(got, {req, " packet appears"}, got, 1);
        chk(rx_n == ex_n, {req, " byte count"}, rx_n, ex_n);
        for (int i = 0; i < ex_n && i < rx_n; i++) begin
            if (mism < 0 && rx[i] !== ex[i]) mism = i;
        end
        if (mism >= 0) chk(1'b0, {req, " byte value"}, rx[mism], ex[mism]);
        else chk(1'b1, {req, " byte value"}, 0, 0);
        chk(rx_stuff_ok && rx_align_ok, {req, " R5 stuffing/alignment"}, rx_stuff_ok, 1);
        chk(rx_eop_ok, {req, " R6 end of packet"}, rx_eop_ok, 1);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: tok_in_a = 1'b1;
            1: tok_setup_a = 1'b1;
            2: tok_in_b = 1'b1;
            default: tok_setup_b = 1'b1;
        endcase
        @(negedge clk);
        tok_in_a = 1'b0; tok_setup_a = 1'b0; tok_in_b = 1'b0; tok_setup_b = 1'b0;
    endtask

    task automatic put_image(input logic [3:0] sel, input int n);
        @(negedge clk);
        img_open = 1'b1; img_sel = sel;
        @(negedge clk);
        img_open = 1'b0;
        for (int i = 0; i < n; i++) begin
            img_wr = 1'b1; img_byte = wbuf[i];
            @(negedge clk);
        end
        img_wr = 1'b0;
    endtask

    task automatic expect_nak();
        ex_n = 2; ex[0] = 8'h80; ex[1] = 8'h5A;
    endtask

    task automatic t_reset();
        chk(oe_a == 1'b0 && dp_a == 1'b0 && dm_a == 1'b0, "R1 reset idle",
            {oe_a, dp_a, dm_a}, 0);
    endtask

    task automatic t_nak_empty();
        bit got;
        pulse(0);
        capture(1'b0, got);
        expect_nak();
        check_pkt("R7 R4 NAK on empty", got);
        chk(oe_a == 1'b0 && dp_a == 1'b0 && dm_a == 1'b0, "R1 released after packet",
            {oe_a, dp_a, dm_a}, 0);
    endtask

    task automatic t_fw_image();
        bit got;
        wbuf[0] = 8'h80; wbuf[1] = 8'hC3; wbuf[2] = 8'h11; wbuf[3] = 8'h22;
        wbuf[4] = 8'h34; wbuf[5] = 8'h12; wbuf[6] = 8'hFF;
        put_image(4'd0, 7);
        pulse(0);
        capture(1'b0, got);
        ex_n = 6;
        for (int i = 0; i < 6; i++) ex[i] = wbuf[i];
        check_pkt("R2 firmware CRC image", got);
    endtask

    task automatic t_empty_after();
        bit got;
        pulse(0);
        capture(1'b0, got);
        expect_nak();
        check_pkt("R9 empty after send", got);
    endtask

    task automatic t_hw_crc();
        bit got;
        logic [15:0] c;
        wbuf[0] = 8'h80; wbuf[1] = 8'h4B; wbuf[2] = 8'h01; wbuf[3] = 8'h02;
        wbuf[4] = 8'h03; wbuf[5] = 8'hFF;
        put_image(4'd3, 6);
        pulse(0);
        capture(1'b0, got);
        ex_n = 7;
        for (int i = 0; i < 5; i++) ex[i] = wbuf[i];
        c = crc_bytes(2, 3);
        ex[5] = c[7:0]; ex[6] = c[15:8];
        check_pkt("R3 hardware CRC three bytes", got);
    endtask

    task automatic t_stuff_heavy();
        bit got;
        logic [15:0] c;
        wbuf[0] = 8'h80; wbuf[1] = 8'hC3;
        for (int i = 2; i < 10; i++) wbuf[i] = 8'hFF;
        wbuf[10] = 8'h00;
        put_image(4'd15, 11);
        pulse(0);
        capture(1'b0, got);
        ex_n = 12;
        for (int i = 0; i < 10; i++) ex[i] = wbuf[i];
        c = crc_bytes(2, 8);
        ex[10] = c[7:0]; ex[11] = c[15:8];
        check_pkt("R5 R3 all-ones payload, clamped count", got);
        wbuf[0] = 8'h80; wbuf[1] = 8'hD2 ^ 8'h11; wbuf[2] = 8'hFE; wbuf[3] = 8'h7F;
        wbuf[4] = 8'hFF;
        put_image(4'd2, 5);
        pulse(0);
        capture(1'b0, got);
        ex_n = 6;
        for (int i = 0; i < 4; i++) ex[i] = wbuf[i];
        c = crc_bytes(2, 2);
        ex[4] = c[7:0]; ex[5] = c[15:8];
        check_pkt("R5 run across byte boundary", got);
    endtask

    task automatic t_setup();
        bit got;
        pulse(1);
        capture(1'b0, got);
        ex_n = 2; ex[0] = 8'h80; ex[1] = 8'hD2;
        check_pkt("R8 SETUP on empty endpoint 0 gives ACK", got);
        wbuf[0] = 8'h80; wbuf[1] = 8'hC3; wbuf[2] = 8'h5A; wbuf[3] = 8'hA5;
        wbuf[4] = 8'hFF;
        put_image(4'd0, 5);
        pulse(1);
        capture(1'b0, got);
        ex_n = 4;
        for (int i = 0; i < 4; i++) ex[i] = wbuf[i];
        check_pkt("R8 SETUP with image sends it", got);
        pulse(3);
        capture(1'b1, got);
        chk(!got, "R8 SETUP ignored on other endpoint", got, 0);
        pulse(2);
        capture(1'b1, got);
        expect_nak();
        check_pkt("R7 NAK on other endpoint", got);
    endtask

    task automatic t_busy_token();
        bit got, seen = 1'b0;
        fork
            capture(1'b0, got);
            begin
                pulse(0);
                repeat (40) @(negedge clk);
                pulse(0);
            end
        join
        expect_nak();
        check_pkt("R10 token while busy", got);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (oe_a) seen = 1'b1;
        end
        chk(!seen, "R10 no second packet", seen, 0);
    endtask

    task automatic t_closed_writes();
        bit got;
        wbuf[0] = 8'h80; wbuf[1] = 8'hC3; wbuf[2] = 8'hAA; wbuf[3] = 8'hBB;
        wbuf[4] = 8'hFF; wbuf[5] = 8'h55; wbuf[6] = 8'h66; wbuf[7] = 8'hFF;
        put_image(4'd0, 8);
        pulse(0);
        capture(1'b0, got);
        ex_n = 4;
        for (int i = 0; i < 4; i++) ex[i] = wbuf[i];
        check_pkt("R11 writes after close ignored", got);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nak_empty();
        t_fw_image();
        t_empty_after();
        t_hw_crc();
        t_stuff_heavy();
        t_setup();
        t_busy_token();
        t_closed_writes();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule